// File: doc/BRIEF.md
# PSRAM Power and Low-Power Sequencer

This block sits on the controller side of a pseudo-static RAM. It owns the two pins that govern the RAM's power state: an active-low chip select and the refresh-mode pin, whose high level means normal refresh. After the supply becomes valid it runs the power-up sequence. It then reports ready. On request it moves the RAM into a low-power partial-refresh state and brings it back out again.

Every wait is a whole number of clock cycles. These counts are worked out at elaboration from a clock-period parameter and rounded up. While the block reports ready, an access controller's chip-select request passes through to the RAM. Otherwise chip select is held high. A second block writes the mode register, and read and write data cycles are outside this block.

The refresh density to keep during low power is sampled when the sleep request is accepted. The wake path depends on that stored value. When some array is retained, the wake is a short guard delay. When nothing is retained, the RAM must go through the full power-up sequence again.

Top module: `psram_lp_seq`

## Requirements
- R1: While reset is asserted or supply is not good, the refresh-mode pin is low, chip select is high, and ready and busy are both low.
- R2: When supply becomes good, the block enters initialization on the next clock edge. It then holds the refresh-mode pin low with busy high for exactly ceil(50 us / clock period) cycles, which is 5000 cycles at 100 MHz.
- R3: Chip select is high in the cycle before the refresh-mode pin rises and in the cycle of the rise.
- R4: After the refresh-mode pin rises during initialization, both pins stay high with busy set for exactly ceil(200 us / clock period) cycles (20000 at 100 MHz). Then ready rises and busy falls in the same cycle.
- R5: While ready, chip select follows the access chip-select input in the same cycle. At all other times it is high.
- R6: A sleep request sampled while ready forces chip select high and sets busy for one cycle with the refresh-mode pin still high. In the following cycle the refresh-mode pin goes low and busy clears.
- R7: Density code on the 2-bit density input: 00 keeps 16 Mbit, 01 keeps 8 Mbit, 10 keeps 4 Mbit, 11 keeps nothing. A wake request sampled in low power with a stored code other than 11 raises the refresh-mode pin at once. Chip select is held high with busy set for ceil(30 ns / clock period) cycles (3 at 100 MHz), and then ready rises.
- R8: A wake request with stored code 11 repeats the full sequence of R2 and R4: the pin stays low for the R2 count, then high for the R4 count, before ready.
- R9: The density code is sampled only when a sleep request is accepted. Changing the input while in low power does not change the wake path.
- R10: A sleep request outside the ready state is ignored, and so is a wake request outside the low-power state. No later state change results from them.
- R11: A drop of supply-good forces the refresh-mode pin low, chip select high and ready low in the same cycle, from any state. When supply returns, the full sequence of R2 and R4 runs again.
- R12: Busy and ready are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | RAM supply is valid |
| dens_i | input | 2 | Refresh density code kept in low power (see R7) |
| sleep_req_i | input | 1 | Request to enter low power, sampled each clock |
| wake_req_i | input | 1 | Request to leave low power, sampled each clock |
| acc_cs_n_i | input | 1 | Chip-select request from the access controller, active low |
| psram_cs_n_o | output | 1 | RAM chip select, active low |
| rfsh_o | output | 1 | RAM refresh-mode pin, high for normal refresh |
| ready_o | output | 1 | RAM available for normal access |
| busy_o | output | 1 | A power sequence is in progress |

## Verification
The pins decode directly from the state register and are gated combinationally by supply-good and the access chip select. A request sampled at one clock edge therefore shows its effect in the cycle right after that edge. A supply drop or an access chip-select change shows up in the same cycle. The bench drives every input on the falling edge and samples one falling edge later, or 1 ns after a supply or chip-select change. Each timed phase is measured by counting falling edges while the phase's pin pattern holds. The counts are then compared against exact cycle totals worked out from the delays at 10 ns per cycle: 5000 low, 20000 high and 3 for the short wake.

// File: rtl/psram_lp_pkg.sv
`timescale 1ns/1ps
package psram_lp_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_INIT_LO = 3'd1,
    ST_INIT_HI = 3'd2,
    ST_RUN     = 3'd3,
    ST_SLP_CS  = 3'd4,
    ST_SLEEP   = 3'd5,
    ST_WAKE    = 3'd6
  } lp_state_e;

  // density code kept while in low power; DENS_NONE forces full re-init
  typedef enum logic [1:0] {
    DENS_16M  = 2'b00,
    DENS_8M   = 2'b01,
    DENS_4M   = 2'b10,
    DENS_NONE = 2'b11
  } dens_e;

  // delay in ps rounded up to whole clock cycles, at least one
  function automatic int unsigned dly_cycles(input longint unsigned dly_ps,
                                             input longint unsigned per_ps);
    longint unsigned n;
    n = (dly_ps + per_ps - 64'd1) / per_ps;
    if (n == 64'd0) n = 64'd1;
    return n[31:0];
  endfunction

endpackage

// File: rtl/psram_lp_timer.sv
`timescale 1ns/1ps
module psram_lp_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/psram_lp_fsm.sv
`timescale 1ns/1ps
module psram_lp_fsm
  import psram_lp_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned N_LO = 5000,
  parameter int unsigned N_HI = 20000,
  parameter int unsigned N_WK = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_ok_i,
  input  logic         sleep_req_i,
  input  logic         wake_req_i,
  input  logic [1:0]   dens_i,
  input  logic         tmr_done_i,
  output lp_state_e    state_o,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o
);

  localparam logic [W-1:0] LD_LO = W'(N_LO - 1);
  localparam logic [W-1:0] LD_HI = W'(N_HI - 1);
  localparam logic [W-1:0] LD_WK = W'(N_WK - 1);

  lp_state_e st_q, st_d;
  dens_e     dens_q, dens_d;

  always_comb begin
    st_d       = st_q;
    dens_d     = dens_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (st_q)
      ST_OFF: if (supply_ok_i) begin
        st_d = ST_INIT_LO; tmr_load_o = 1'b1; tmr_val_o = LD_LO;
      end
      ST_INIT_LO: if (tmr_done_i) begin
        st_d = ST_INIT_HI; tmr_load_o = 1'b1; tmr_val_o = LD_HI;
      end
      ST_INIT_HI: if (tmr_done_i) st_d = ST_RUN;
      ST_RUN: if (sleep_req_i) begin
        st_d = ST_SLP_CS; dens_d = dens_e'(dens_i);
      end
      ST_SLP_CS: st_d = ST_SLEEP;
      ST_SLEEP: if (wake_req_i) begin
        tmr_load_o = 1'b1;
        if (dens_q == DENS_NONE) begin
          st_d = ST_INIT_LO; tmr_val_o = LD_LO;
        end else begin
          st_d = ST_WAKE; tmr_val_o = LD_WK;
        end
      end
      ST_WAKE: if (tmr_done_i) st_d = ST_RUN;
      default: st_d = ST_OFF;
    endcase
    if (!supply_ok_i) begin
      st_d       = ST_OFF;
      tmr_load_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      dens_q <= DENS_16M;
    end else begin
      st_q   <= st_d;
      dens_q <= dens_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/psram_lp_pins.sv
`timescale 1ns/1ps
module psram_lp_pins
  import psram_lp_pkg::*;
(
  input  lp_state_e state_i,
  input  logic      supply_ok_i,
  input  logic      acc_cs_n_i,
  output logic      cs_n_o,
  output logic      rfsh_o,
  output logic      ready_o,
  output logic      busy_o
);

  logic rfsh_s, ready_s, busy_s;

  always_comb begin
    rfsh_s  = 1'b0;
    ready_s = 1'b0;
    busy_s  = 1'b0;
    unique case (state_i)
      ST_INIT_LO: busy_s = 1'b1;
      ST_INIT_HI: begin rfsh_s = 1'b1; busy_s = 1'b1; end
      ST_RUN:     begin rfsh_s = 1'b1; ready_s = 1'b1; end
      ST_SLP_CS:  begin rfsh_s = 1'b1; busy_s = 1'b1; end
      ST_WAKE:    begin rfsh_s = 1'b1; busy_s = 1'b1; end
      default:    ;
    endcase
  end

  // a supply drop overrides the state at once
  assign rfsh_o  = rfsh_s  & supply_ok_i;
  assign ready_o = ready_s & supply_ok_i;
  assign busy_o  = busy_s  & supply_ok_i;
  assign cs_n_o  = ~(ready_o & ~acc_cs_n_i);

endmodule

// File: rtl/psram_lp_seq.sv
`timescale 1ns/1ps
module psram_lp_seq
  import psram_lp_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned INIT_LOW_NS   = 50000,
  parameter int unsigned INIT_HIGH_NS  = 200000,
  parameter int unsigned WAKE_NS       = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok_i,
  input  logic [1:0] dens_i,
  input  logic       sleep_req_i,
  input  logic       wake_req_i,
  input  logic       acc_cs_n_i,
  output logic       psram_cs_n_o,
  output logic       rfsh_o,
  output logic       ready_o,
  output logic       busy_o
);

  localparam longint unsigned PER = 64'(CLK_PERIOD_PS);
  localparam int unsigned N_LO = dly_cycles(64'(INIT_LOW_NS)  * 64'd1000, PER);
  localparam int unsigned N_HI = dly_cycles(64'(INIT_HIGH_NS) * 64'd1000, PER);
  localparam int unsigned N_WK = dly_cycles(64'(WAKE_NS)      * 64'd1000, PER);
  localparam int unsigned N_MX = (N_LO > N_HI) ? ((N_LO > N_WK) ? N_LO : N_WK)
                                               : ((N_HI > N_WK) ? N_HI : N_WK);
  localparam int unsigned W    = (N_MX < 2) ? 1 : $clog2(N_MX);

  lp_state_e    state;
  logic         tmr_load, tmr_done;
  logic [W-1:0] tmr_val;

  psram_lp_fsm #(.W(W), .N_LO(N_LO), .N_HI(N_HI), .N_WK(N_WK)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok_i(supply_ok_i),
    .sleep_req_i(sleep_req_i),
    .wake_req_i (wake_req_i),
    .dens_i     (dens_i),
    .tmr_done_i (tmr_done),
    .state_o    (state),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val)
  );

  psram_lp_timer #(.W(W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .done_o(tmr_done)
  );

  psram_lp_pins u_pins (
    .state_i    (state),
    .supply_ok_i(supply_ok_i),
    .acc_cs_n_i (acc_cs_n_i),
    .cs_n_o     (psram_cs_n_o),
    .rfsh_o     (rfsh_o),
    .ready_o    (ready_o),
    .busy_o     (busy_o)
  );

endmodule

// File: rtl/psram_lp_chk.sv
`timescale 1ns/1ps
module psram_lp_chk
  import psram_lp_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned WAKE_NS       = 30
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic cs_n,
  input logic rfsh,
  input logic ready,
  input logic busy
);

  localparam int unsigned N_WK = dly_cycles(64'(WAKE_NS) * 64'd1000, 64'(CLK_PERIOD_PS));

  // consecutive cycles with both pins high and supply good
  int unsigned hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        hi_cnt <= 0;
    else if (rfsh && cs_n && supply_ok) hi_cnt <= (hi_cnt == 32'hFFFF_FFFF) ? hi_cnt : hi_cnt + 1;
    else                               hi_cnt <= 0;
  end

  assert_supply_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (!rfsh && cs_n && !ready));

  assert_cs_before_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh) |-> ($past(cs_n) && cs_n));

  assert_cs_before_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rfsh) && supply_ok) |-> $past(cs_n));

  assert_cs_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> cs_n);

  assert_wake_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (hi_cnt >= N_WK));

  assert_busy_ready_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ready));

endmodule

bind psram_lp_seq psram_lp_chk #(.CLK_PERIOD_PS(CLK_PERIOD_PS), .WAKE_NS(WAKE_NS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .supply_ok(supply_ok_i),
  .cs_n     (psram_cs_n_o),
  .rfsh     (rfsh_o),
  .ready    (ready_o),
  .busy     (busy_o)
);

// File: tb/test_psram_lp_seq.sv
`timescale 1ns/1ps
module test_psram_lp_seq;

  localparam int N_LO = 5000;   // 50 us at 10 ns
  localparam int N_HI = 20000;  // 200 us at 10 ns
  localparam int N_WK = 3;      // 30 ns at 10 ns

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok_i = 1'b0;
  logic [1:0] dens_i = 2'b00;
  logic       sleep_req_i = 1'b0;
  logic       wake_req_i = 1'b0;
  logic       acc_cs_n_i = 1'b1;
  logic       psram_cs_n_o, rfsh_o, ready_o, busy_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  psram_lp_seq i_psram_lp_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok_i (supply_ok_i),
    .dens_i      (dens_i),
    .sleep_req_i (sleep_req_i),
    .wake_req_i  (wake_req_i),
    .acc_cs_n_i  (acc_cs_n_i),
    .psram_cs_n_o(psram_cs_n_o),
    .rfsh_o      (rfsh_o),
    .ready_o     (ready_o),
    .busy_o      (busy_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  // trigger was driven on the previous falling edge; measure both init phases
  task automatic run_init(input string req, input bit poke);
    int lo = 0;
    int hi = 0;
    int cs_bad = 0;
    @(negedge clk);
    while (busy_o && !rfsh_o && lo < 30000) begin
      if (psram_cs_n_o !== 1'b1) cs_bad++;
      sleep_req_i = poke && (lo == 0);
      wake_req_i  = poke && (lo == 0);
      lo++;
      @(negedge clk);
    end
    sleep_req_i = 1'b0;
    wake_req_i  = 1'b0;
    while (busy_o && rfsh_o && !ready_o && hi < 30000) begin
      if (psram_cs_n_o !== 1'b1) cs_bad++;
      hi++;
      @(negedge clk);
    end
    chk(lo == N_LO, {req, "/R2"}, "init low cycles", lo, N_LO);
    chk(hi == N_HI, {req, "/R4"}, "init high cycles", hi, N_HI);
    chk(cs_bad == 0, "R3", "cycles with cs low during init", cs_bad, 0);
    chk(ready_o && !busy_o, "R4/R12", "ready&!busy after init", {ready_o, busy_o}, 2);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!rfsh_o && psram_cs_n_o && !ready_o && !busy_o, "R1", "pins in reset",
        {rfsh_o, psram_cs_n_o, ready_o, busy_o}, 4);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rfsh_o && psram_cs_n_o && !ready_o && !busy_o, "R1", "pins without supply",
        {rfsh_o, psram_cs_n_o, ready_o, busy_o}, 4);
  endtask

  task automatic t_powerup();
    supply_ok_i = 1'b1;
    run_init("R2", 1'b1);
    repeat (5) @(negedge clk);
    chk(ready_o && rfsh_o, "R10", "requests during init ignored", {ready_o, rfsh_o}, 3);
  endtask

  task automatic t_run_cs();
    acc_cs_n_i = 1'b0;
    #1;
    chk(psram_cs_n_o == 1'b0, "R5", "cs follows access low", psram_cs_n_o, 0);
    acc_cs_n_i = 1'b1;
    #1;
    chk(psram_cs_n_o == 1'b1, "R5", "cs follows access high", psram_cs_n_o, 1);
    @(negedge clk);
    wake_req_i = 1'b1;
    @(negedge clk);
    wake_req_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(ready_o && rfsh_o && !busy_o, "R10", "wake in ready ignored",
        {ready_o, rfsh_o, busy_o}, 6);
  endtask

  task automatic t_sleep(input logic [1:0] code);
    dens_i      = code;
    acc_cs_n_i  = 1'b0;
    sleep_req_i = 1'b1;
    @(negedge clk);
    sleep_req_i = 1'b0;
    chk(psram_cs_n_o && rfsh_o && busy_o && !ready_o, "R6", "cs raised first",
        {psram_cs_n_o, rfsh_o, busy_o, ready_o}, 14);
    @(negedge clk);
    chk(psram_cs_n_o && !rfsh_o && !busy_o && !ready_o, "R6", "refresh pin low next",
        {psram_cs_n_o, rfsh_o, busy_o, ready_o}, 8);
    sleep_req_i = 1'b1;
    @(negedge clk);
    sleep_req_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rfsh_o && !busy_o && !ready_o && psram_cs_n_o, "R10", "sleep while asleep ignored",
        {rfsh_o, busy_o, ready_o, psram_cs_n_o}, 1);
  endtask

  task automatic t_wake_short();
    int n = 0;
    int cs_bad = 0;
    dens_i     = 2'b11;   // changed while asleep: must not matter (R9)
    acc_cs_n_i = 1'b0;
    wake_req_i = 1'b1;
    @(negedge clk);
    wake_req_i = 1'b0;
    while (busy_o && rfsh_o && !ready_o && n < 100) begin
      if (psram_cs_n_o !== 1'b1) cs_bad++;
      n++;
      @(negedge clk);
    end
    chk(n == N_WK, "R7/R9", "short wake guard cycles", n, N_WK);
    chk(cs_bad == 0, "R7", "cs high in guard", cs_bad, 0);
    chk(ready_o && psram_cs_n_o == 1'b0, "R7/R5", "ready and cs passes",
        {ready_o, psram_cs_n_o}, 2);
    acc_cs_n_i = 1'b1;
  endtask

  task automatic t_wake_full();
    dens_i     = 2'b00;   // changed while asleep: stored 11 still rules (R9)
    wake_req_i = 1'b1;
    run_init("R8/R9", 1'b0);
  endtask

  task automatic t_drop_run();
    acc_cs_n_i = 1'b0;
    #1;
    supply_ok_i = 1'b0;
    #1;
    chk(!rfsh_o && psram_cs_n_o && !ready_o && !busy_o, "R11", "drop in ready",
        {rfsh_o, psram_cs_n_o, ready_o, busy_o}, 4);
    acc_cs_n_i = 1'b1;
    repeat (3) @(negedge clk);
    supply_ok_i = 1'b1;
    run_init("R11", 1'b0);
  endtask

  task automatic t_drop_init();
    supply_ok_i = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok_i = 1'b1;
    repeat (N_LO + 50) @(negedge clk);
    chk(rfsh_o && busy_o, "R4", "in high phase", {rfsh_o, busy_o}, 3);
    supply_ok_i = 1'b0;
    #1;
    chk(!rfsh_o && !busy_o && !ready_o, "R11", "drop during init",
        {rfsh_o, busy_o, ready_o}, 0);
    repeat (3) @(negedge clk);
    supply_ok_i = 1'b1;
    run_init("R11", 1'b0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_powerup();
    t_run_cs();
    t_sleep(2'b00);
    t_wake_short();
    @(negedge clk);
    t_sleep(2'b11);
    t_wake_full();
    t_drop_run();
    t_drop_init();
    summary();
    $finish;
  end

endmodule